// File: doc/BRIEF.md
# Boundary Register with Self-Test Pattern Modes

This block is the boundary-register logic for a bus transceiver. It has one scan cell for each input pin and one for each output pin. An external IEEE 1149.1 controller supplies the latched instruction opcode and four TAP-state strobes: capture, shift, update and run-test-idle. From these the block selects between the boundary chain and a one-bit bypass stage for `tdo`. It also chooses whether the output pads carry the functional datapath, the boundary update stage, or nothing at all.

The conventional instructions are sample/preload, external test, clamp and high-impedance. The block also has self-test instructions that reuse the same cells. Each one steps once per test clock while the controller sits in run-test-idle. The input cells can fold the pin values into a multiple-input signature. The output update stage can act as a maximal-length LFSR or as a binary counter, and one instruction combines the signature with the counter. A further instruction samples the inputs while inverting the outputs. Opcodes have even parity, and any opcode that is not recognised selects bypass with the functional datapath.

Top module: `bscan_boundary`

## Requirements
- R1: An opcode with odd parity, or an even-parity opcode other than 8'h00, 8'h03, 8'h05, 8'h06, 8'h09, 8'h0A, 8'h0C, 8'h0F, 8'h11 or 8'hFF, acts as bypass. `sel_bypass` is 1 and the pads follow `core_out` and `core_oe`.
- R2: The shift strobe moves the chain one place per rising `tck`. Data runs from `tdi` into input cell N_IN-1, down to input cell 0, then into output cell N_OUT-1, down to output cell 0, which drives `tdo`.
- R3: The capture strobe loads the input cells from `pin_in` and the output cells from the current `pad_out` value.
- R4: The update strobe copies the output cells into the update stage on the falling `tck` edge, not on the rising edge. Under sample/preload (8'h03) the pads still carry `core_out`.
- R5: Under external test (8'h00) `pad_out` equals the update stage and `pad_oe` is 1.
- R6: Under clamp (8'h05) `pad_out` holds the update stage with `pad_oe` 1. `tdo` comes from a one-bit bypass stage that captures 0 and shifts `tdi`.
- R7: Under high-impedance (8'h06) `pad_oe` is 0 and bypass is selected.
- R8: Under signature mode (8'h09) each run-test-idle rising edge sets input cell i to cell i-1 XOR `pin_in[i]`. Cell 0 takes the XOR of cells 17 and 10 with `pin_in[0]`. The pads carry the update stage.
- R9: Under pattern mode (8'h0A) each run-test-idle falling edge shifts the update stage left, bringing in the XOR of bits 17 and 10. An all-zero stage becomes 1.
- R10: Under count mode (8'h0C) each run-test-idle falling edge adds one to the update stage, wrapping from all-ones to zero.
- R11: Under combined mode (8'h0F) the input cells follow R8 while the update stage counts as in R10.
- R12: Under toggle mode (8'h11) each run-test-idle rising edge loads the input cells from `pin_in`, and each falling edge inverts the update stage.
- R13: While `trst_n` is low every cell, the update stage and the bypass stage are zero, so `tdo` is 0.
- R14: Under sample/preload and bypass (8'hFF), `pad_out` and `pad_oe` equal `core_out` and `core_oe` whatever the scan strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| opcode | input | 8 | Current instruction from the controller |
| st_capture | input | 1 | Controller is in capture-DR |
| st_shift | input | 1 | Controller is in shift-DR |
| st_update | input | 1 | Controller is in update-DR |
| st_rti | input | 1 | Controller is in run-test-idle |
| tdi | input | 1 | Serial test data in |
| pin_in | input | N_IN | Values seen at the input pads |
| core_out | input | N_OUT | Functional output data |
| core_oe | input | 1 | Functional output enable |
| tdo | output | 1 | Serial test data out |
| pad_out | output | N_OUT | Data to the output pads |
| pad_oe | output | 1 | Output pad enable |
| sel_bypass | output | 1 | Bypass stage currently selected |

## Verification
The hardest state to reach from the ports is a signature left in the input cells after many run-test-idle steps. It can only be seen by going straight from run-test-idle into shift, so that no capture overwrites it, and then clocking out the whole chain. The stimulus runs signature and combined modes over a varying pin sequence and then unloads the chain without a capture. The same path reaches the pattern generator's zero escape: a preload of all zeros through update is followed by idle steps. The counter's wrap is reached the same way, by preloading one below all-ones.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   localparam int IR_W = 8;

   localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
   localparam logic [IR_W-1:0] OP_SAMPLE = 8'h03;
   localparam logic [IR_W-1:0] OP_CLAMP  = 8'h05;
   localparam logic [IR_W-1:0] OP_HIGHZ  = 8'h06;
   localparam logic [IR_W-1:0] OP_SIG    = 8'h09;
   localparam logic [IR_W-1:0] OP_PRPG   = 8'h0A;
   localparam logic [IR_W-1:0] OP_COUNT  = 8'h0C;
   localparam logic [IR_W-1:0] OP_SIGCNT = 8'h0F;
   localparam logic [IR_W-1:0] OP_TOGGLE = 8'h11;
   localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;

   // decoded control for the boundary register
   typedef struct packed {
      logic byp;    // bypass stage feeds tdo
      logic drv;    // pads carry the update stage, enabled
      logic hiz;    // pads disabled
      logic sig;    // input cells compress pins
      logic prpg;   // update stage runs as LFSR
      logic cnt;    // update stage counts
      logic tgl;    // sample inputs, invert outputs
   } bs_ctl_t;

endpackage

// File: rtl/bscan_decode.sv
module bscan_decode
   import bscan_pkg::*;
(
   input  logic            tck,
   input  logic            rst_n,
   input  logic [IR_W-1:0] opcode,
   output bs_ctl_t         ctl
);

   logic par_ok;
   assign par_ok = ~(^opcode);

   always_comb begin
      ctl     = '0;
      ctl.byp = 1'b1;
      if (par_ok) begin
         case (opcode)
            OP_EXTEST: begin ctl.byp = 1'b0; ctl.drv = 1'b1; end
            OP_SAMPLE: begin ctl.byp = 1'b0; end
            OP_CLAMP:  begin ctl.drv = 1'b1; end
            OP_HIGHZ:  begin ctl.hiz = 1'b1; end
            OP_SIG:    begin ctl.byp = 1'b0; ctl.drv = 1'b1; ctl.sig = 1'b1; end
            OP_PRPG:   begin ctl.byp = 1'b0; ctl.drv = 1'b1; ctl.prpg = 1'b1; end
            OP_COUNT:  begin ctl.byp = 1'b0; ctl.drv = 1'b1; ctl.cnt = 1'b1; end
            OP_SIGCNT: begin ctl.byp = 1'b0; ctl.drv = 1'b1; ctl.sig = 1'b1; ctl.cnt = 1'b1; end
            OP_TOGGLE: begin ctl.byp = 1'b0; ctl.drv = 1'b1; ctl.tgl = 1'b1; end
            default:   ;
         endcase
      end
   end

   // R1: a parity failure always lands on the bypass path
   a_r1_bad_parity_bypass: assert property (@(posedge tck) disable iff (!rst_n)
      (^opcode) |-> (ctl.byp && !ctl.drv && !ctl.hiz));

   // at most one output-stage self-test action at a time
   a_r11_single_out_mode: assert property (@(posedge tck) disable iff (!rst_n)
      $onehot0({ctl.prpg, ctl.cnt, ctl.tgl}));

endmodule

// File: rtl/bscan_in_cells.sv
module bscan_in_cells #(
   parameter int          N    = 18,
   parameter logic [N-1:0] TAPS = N'(18'h20400)
) (
   input  logic         tck,
   input  logic         rst_n,
   input  logic         dr_sel,
   input  logic         st_capture,
   input  logic         st_shift,
   input  logic         st_rti,
   input  logic         sig_en,
   input  logic         tgl_en,
   input  logic         si,
   input  logic [N-1:0] pins,
   output logic         so,
   output logic [N-1:0] cells
);

   logic         fb;
   logic [N-1:0] misr_nxt;

   assign fb = ^(cells & TAPS);

   for (genvar i = 0; i < N; i++) begin : g_misr
      if (i == 0) begin : g_head
         assign misr_nxt[i] = fb ^ pins[i];
      end else begin : g_body
         assign misr_nxt[i] = cells[i-1] ^ pins[i];
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         cells <= '0;
      end else if (dr_sel) begin
         if (st_capture)
            cells <= pins;
         else if (st_shift)
            cells <= {si, cells[N-1:1]};
         else if (st_rti && sig_en)
            cells <= misr_nxt;
         else if (st_rti && tgl_en)
            cells <= pins;
      end
   end

   assign so = cells[0];

   // R3: capture takes the pins
   a_r3_capture_pins: assert property (@(posedge tck) disable iff (!rst_n)
      (dr_sel && st_capture) |=> (cells == $past(pins)));

   // R2: serial input enters the top input cell
   a_r2_shift_entry: assert property (@(posedge tck) disable iff (!rst_n)
      (dr_sel && st_shift && !st_capture) |=> (cells[N-1] == $past(si)));

endmodule

// File: rtl/bscan_out_cells.sv
module bscan_out_cells #(
   parameter int          N    = 18,
   parameter logic [N-1:0] TAPS = N'(18'h20400)
) (
   input  logic         tck,
   input  logic         rst_n,
   input  logic         dr_sel,
   input  logic         st_capture,
   input  logic         st_shift,
   input  logic         st_update,
   input  logic         st_rti,
   input  logic         prpg_en,
   input  logic         cnt_en,
   input  logic         tgl_en,
   input  logic         si,
   input  logic [N-1:0] pad_val,
   output logic         so,
   output logic [N-1:0] upd
);

   logic [N-1:0] sh;
   logic [N-1:0] lfsr_nxt;

   assign lfsr_nxt = (upd == '0) ? N'(1) : {upd[N-2:0], ^(upd & TAPS)};

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
      end else if (dr_sel) begin
         if (st_capture)
            sh <= pad_val;
         else if (st_shift)
            sh <= {si, sh[N-1:1]};
      end
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         upd <= '0;
      end else if (st_update) begin
         if (dr_sel)
            upd <= sh;
      end else if (st_rti) begin
         if (prpg_en)
            upd <= lfsr_nxt;
         else if (cnt_en)
            upd <= upd + 1'b1;
         else if (tgl_en)
            upd <= ~upd;
      end
   end

   assign so = sh[0];

   // R9: the generator never rests in the all-zero state
   a_r9_prpg_nonzero: assert property (@(negedge tck) disable iff (!rst_n)
      (st_rti && !st_update && prpg_en) |=> (upd != '0));

   // R10: one increment per idle clock
   a_r10_count_step: assert property (@(negedge tck) disable iff (!rst_n)
      (st_rti && !st_update && cnt_en && !prpg_en) |=> (upd == $past(upd) + 1'b1));

   // R12: toggle inverts every bit
   a_r12_toggle_invert: assert property (@(negedge tck) disable iff (!rst_n)
      (st_rti && !st_update && tgl_en && !prpg_en && !cnt_en) |=> (upd == ~$past(upd)));

endmodule

// File: rtl/bscan_boundary.sv
module bscan_boundary
   import bscan_pkg::*;
#(
   parameter int               N_IN     = 18,
   parameter int               N_OUT    = 18,
   parameter logic [N_IN-1:0]  IN_TAPS  = N_IN'(18'h20400),
   parameter logic [N_OUT-1:0] OUT_TAPS = N_OUT'(18'h20400)
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic [IR_W-1:0]  opcode,
   input  logic             st_capture,
   input  logic             st_shift,
   input  logic             st_update,
   input  logic             st_rti,
   input  logic             tdi,
   input  logic [N_IN-1:0]  pin_in,
   input  logic [N_OUT-1:0] core_out,
   input  logic             core_oe,
   output logic             tdo,
   output logic [N_OUT-1:0] pad_out,
   output logic             pad_oe,
   output logic             sel_bypass
);

   if (N_IN < 2) begin : g_bad_nin
      $error("bscan_boundary: N_IN must be at least 2");
   end
   if (N_OUT < 2) begin : g_bad_nout
      $error("bscan_boundary: N_OUT must be at least 2");
   end
   if (!IN_TAPS[N_IN-1]) begin : g_bad_itap
      $error("bscan_boundary: IN_TAPS must include the top bit");
   end
   if (!OUT_TAPS[N_OUT-1]) begin : g_bad_otap
      $error("bscan_boundary: OUT_TAPS must include the top bit");
   end

   bs_ctl_t          ctl;
   logic             dr_sel;
   logic             link;
   logic             out_so;
   logic             byp_q;
   logic [N_OUT-1:0] upd;

   bscan_decode u_dec (
      .tck    (tck),
      .rst_n  (trst_n),
      .opcode (opcode),
      .ctl    (ctl)
   );

   assign dr_sel = ~ctl.byp;

   bscan_in_cells #(.N(N_IN), .TAPS(IN_TAPS)) u_in (
      .tck        (tck),
      .rst_n      (trst_n),
      .dr_sel     (dr_sel),
      .st_capture (st_capture),
      .st_shift   (st_shift),
      .st_rti     (st_rti),
      .sig_en     (ctl.sig),
      .tgl_en     (ctl.tgl),
      .si         (tdi),
      .pins       (pin_in),
      .so         (link),
      .cells      ()
   );

   bscan_out_cells #(.N(N_OUT), .TAPS(OUT_TAPS)) u_out (
      .tck        (tck),
      .rst_n      (trst_n),
      .dr_sel     (dr_sel),
      .st_capture (st_capture),
      .st_shift   (st_shift),
      .st_update  (st_update),
      .st_rti     (st_rti),
      .prpg_en    (ctl.prpg),
      .cnt_en     (ctl.cnt),
      .tgl_en     (ctl.tgl),
      .si         (link),
      .pad_val    (pad_out),
      .so         (out_so),
      .upd        (upd)
   );

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)
         byp_q <= 1'b0;
      else if (ctl.byp) begin
         if (st_capture)
            byp_q <= 1'b0;
         else if (st_shift)
            byp_q <= tdi;
      end
   end

   assign tdo        = ctl.byp ? byp_q : out_so;
   assign pad_out    = (ctl.drv || ctl.hiz) ? upd : core_out;
   assign pad_oe     = ctl.hiz ? 1'b0 : (ctl.drv ? 1'b1 : core_oe);
   assign sel_bypass = ctl.byp;

   // R7: high-impedance instruction disables the pads
   a_r7_highz_off: assert property (@(posedge tck) disable iff (!trst_n)
      (opcode == OP_HIGHZ) |-> (!pad_oe && sel_bypass));

   // R14: normal-mode instructions leave the functional path untouched
   a_r14_passthrough: assert property (@(posedge tck) disable iff (!trst_n)
      (opcode == OP_SAMPLE || opcode == OP_BYPASS) |-> (pad_out == core_out && pad_oe == core_oe));

   // R6: a clamped output holds while clamp stays selected
   a_r6_clamp_hold: assert property (@(posedge tck) disable iff (!trst_n)
      (opcode == OP_CLAMP) |=> ((opcode != OP_CLAMP) || $stable(pad_out)));

endmodule

// File: tb/bscan_boundary_bench.sv
module bscan_boundary_bench;

   localparam int NI = 18;
   localparam int NO = 18;
   localparam int NC = NI + NO;

   logic          tck = 1'b0;
   logic          trst_n;
   logic [7:0]    opcode;
   logic          st_capture, st_shift, st_update, st_rti;
   logic          tdi;
   logic [NI-1:0] pin_in;
   logic [NO-1:0] core_out;
   logic          core_oe;
   logic          tdo;
   logic [NO-1:0] pad_out;
   logic          pad_oe;
   logic          sel_bypass;

   bscan_boundary u_bscan_boundary (
      .tck(tck), .trst_n(trst_n), .opcode(opcode),
      .st_capture(st_capture), .st_shift(st_shift), .st_update(st_update), .st_rti(st_rti),
      .tdi(tdi), .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
      .tdo(tdo), .pad_out(pad_out), .pad_oe(pad_oe), .sel_bypass(sel_bypass)
   );

   always #10 tck = ~tck;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 0;

   // behavioural reference state
   logic [NI-1:0] m_in;
   logic [NO-1:0] m_sh;
   logic [NO-1:0] m_upd;
   logic          m_byp;

   task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
      end
   endtask

   // 0 bypass, 1 sample, 2 extest, 3 clamp, 4 highz, 5 sig, 6 prpg, 7 count, 8 sig+count, 9 toggle
   function automatic int mdec(input logic [7:0] op);
      if ($countones(op) % 2 != 0) return 0;
      case (op)
         8'h00: return 2;
         8'h03: return 1;
         8'h05: return 3;
         8'h06: return 4;
         8'h09: return 5;
         8'h0A: return 6;
         8'h0C: return 7;
         8'h0F: return 8;
         8'h11: return 9;
         default: return 0;
      endcase
   endfunction

   function automatic bit is_byp(input int md);
      return (md == 0 || md == 3 || md == 4);
   endfunction

   function automatic bit drives(input int md);
      return (md >= 2 && md != 4);
   endfunction

   function automatic logic [NO-1:0] exp_pad();
      int md = mdec(opcode);
      return (drives(md) || md == 4) ? m_upd : core_out;
   endfunction

   function automatic logic exp_oe();
      int md = mdec(opcode);
      if (md == 4) return 1'b0;
      return drives(md) ? 1'b1 : core_oe;
   endfunction

   task automatic model_pos();
      int            md = mdec(opcode);
      logic [NI-1:0] ni = m_in;
      logic [NO-1:0] ns = m_sh;
      if (!trst_n) begin
         m_in = '0; m_sh = '0; m_byp = 1'b0;
         return;
      end
      if (is_byp(md)) begin
         if (st_capture) m_byp = 1'b0;
         else if (st_shift) m_byp = tdi;
         return;
      end
      if (st_capture) begin
         ni = pin_in;
         ns = exp_pad();
      end else if (st_shift) begin
         ns = (m_sh >> 1) | (NO'(m_in[0]) << (NO - 1));
         ni = (m_in >> 1) | (NI'(tdi) << (NI - 1));
      end else if (st_rti && (md == 5 || md == 8)) begin
         for (int i = 0; i < NI; i++)
            ni[i] = pin_in[i] ^ ((i == 0) ? (m_in[17] ^ m_in[10]) : m_in[i-1]);
      end else if (st_rti && md == 9) begin
         ni = pin_in;
      end
      m_in = ni;
      m_sh = ns;
   endtask

   task automatic model_neg();
      int md = mdec(opcode);
      if (!trst_n) begin
         m_upd = '0;
         return;
      end
      if (st_update) begin
         if (!is_byp(md)) m_upd = m_sh;
      end else if (st_rti) begin
         if (md == 6) m_upd = (m_upd == 0) ? NO'(1) : {m_upd[NO-2:0], m_upd[17] ^ m_upd[10]};
         else if (md == 7 || md == 8) m_upd = m_upd + 1'b1;
         else if (md == 9) m_upd = ~m_upd;
      end
   endtask

   function automatic string pad_tag(input int md);
      case (md)
         2: return "R5";  3: return "R6";  4: return "R7";  5: return "R8";
         6: return "R9";  7: return "R10"; 8: return "R11"; 9: return "R12";
         default: return "R14";
      endcase
   endfunction

   task automatic compare();
      int   md   = mdec(opcode);
      logic etdo = is_byp(md) ? m_byp : m_sh[0];
      chk(tdo === etdo, "R2", 36'(tdo), 36'(etdo));
      chk(pad_out === exp_pad(), pad_tag(md), 36'(pad_out), 36'(exp_pad()));
      chk(pad_oe === exp_oe(), pad_tag(md), 36'(pad_oe), 36'(exp_oe()));
      chk(sel_bypass === is_byp(md), "R1", 36'(sel_bypass), 36'(is_byp(md)));
   endtask

   task automatic tick();
      @(posedge tck); model_pos();
      @(negedge tck); model_neg();
      #5; compare();
   endtask

   task automatic setst(input logic c, input logic s, input logic u, input logic r);
      st_capture = c; st_shift = s; st_update = u; st_rti = r;
   endtask

   task automatic capture();
      setst(1, 0, 0, 0); tick(); setst(0, 0, 0, 0);
   endtask

   task automatic shift_in(input logic [NC-1:0] bits);
      for (int k = 0; k < NC; k++) begin
         tdi = bits[k]; setst(0, 1, 0, 0); tick();
      end
      setst(0, 0, 0, 0); tdi = 1'b0;
   endtask

   task automatic update();
      setst(0, 0, 1, 0); tick(); setst(0, 0, 0, 0);
   endtask

   task automatic load(input logic [NO-1:0] v);
      capture(); shift_in({{NI{1'b0}}, v}); update();
   endtask

   task automatic rti(input int n);
      setst(0, 0, 0, 1);
      for (int k = 0; k < n; k++) tick();
      setst(0, 0, 0, 0);
   endtask

   task automatic read_chain(output logic [NC-1:0] r);
      for (int j = 0; j < NC; j++) begin
         r[j] = tdo; tdi = 1'b0; setst(0, 1, 0, 0); tick();
      end
      setst(0, 0, 0, 0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [NC-1:0] rd;
      logic [NI-1:0] snap;
      trst_n = 1'b0; opcode = 8'hFF; setst(0, 0, 0, 0); tdi = 1'b0;
      pin_in = 18'h1234F; core_out = 18'h2A5A5; core_oe = 1'b1;
      m_in = '0; m_sh = '0; m_upd = '0; m_byp = 1'b0;
      tick(); tick();
      // R13: reset state
      chk(tdo === 1'b0, "R13", 36'(tdo), 36'h0);
      chk(pad_out === core_out, "R13", 36'(pad_out), 36'(core_out));
      chk(sel_bypass === 1'b1, "R13", 36'(sel_bypass), 36'h1);
      trst_n = 1'b1; tick();

      // R14 / R4: preload under sample leaves pads on the core path
      opcode = 8'h03; core_out = 18'h0BEEF; core_oe = 1'b0;
      load(18'h15555);
      chk(pad_out === 18'h0BEEF, "R14", 36'(pad_out), 36'h0BEEF);
      chk(pad_oe === 1'b0, "R14", 36'(pad_oe), 36'h0);

      // R3: capture then unload the whole chain
      capture(); read_chain(rd);
      chk(rd[NO-1:0] === 18'h0BEEF, "R3", 36'(rd[NO-1:0]), 36'h0BEEF);
      chk(rd[NC-1:NO] === 18'h1234F, "R3", 36'(rd[NC-1:NO]), 36'h1234F);

      // R2: a pattern shifted in emerges at tdo in the same order
      shift_in(36'h9_C3A5_7E1B);
      read_chain(rd);
      chk(rd === 36'h9_C3A5_7E1B, "R2", rd, 36'h9_C3A5_7E1B);

      // R5: external test drives the preloaded value
      opcode = 8'h00; tick();
      chk(pad_out === 18'h15555, "R5", 36'(pad_out), 36'h15555);
      chk(pad_oe === 1'b1, "R5", 36'(pad_oe), 36'h1);

      // R4: update takes effect on the falling edge only
      capture(); shift_in({{NI{1'b0}}, 18'h0C3C3});
      setst(0, 0, 1, 0);
      @(posedge tck); model_pos(); #5;
      chk(pad_out === 18'h15555, "R4", 36'(pad_out), 36'h15555);
      @(negedge tck); model_neg(); #5; compare();
      chk(pad_out === 18'h0C3C3, "R4", 36'(pad_out), 36'h0C3C3);
      setst(0, 0, 0, 0);

      // R6: clamp holds the pads and routes through the bypass stage
      opcode = 8'h05; core_out = 18'h00001; tick();
      chk(pad_out === 18'h0C3C3 && sel_bypass === 1'b1, "R6", 36'(pad_out), 36'h0C3C3);
      capture();
      chk(tdo === 1'b0, "R6", 36'(tdo), 36'h0);
      tdi = 1'b1; setst(0, 1, 0, 0); tick(); setst(0, 0, 0, 0);
      chk(tdo === 1'b1, "R6", 36'(tdo), 36'h1);
      update();
      chk(pad_out === 18'h0C3C3, "R6", 36'(pad_out), 36'h0C3C3);

      // R7: high impedance
      opcode = 8'h06; tick();
      chk(pad_oe === 1'b0 && sel_bypass === 1'b1, "R7", 36'(pad_oe), 36'h0);

      // R1: odd parity and unknown opcodes fall back to bypass
      core_oe = 1'b1;
      opcode = 8'h02; tick();
      chk(sel_bypass === 1'b1 && pad_out === core_out, "R1", 36'(pad_out), 36'(core_out));
      opcode = 8'h0B; tick();
      chk(sel_bypass === 1'b1, "R1", 36'(sel_bypass), 36'h1);
      opcode = 8'h30; tick();
      chk(sel_bypass === 1'b1 && pad_oe === 1'b1, "R1", 36'(sel_bypass), 36'h1);

      // R8: signature over a varying pin sequence, read out without capture
      opcode = 8'h09; capture();
      setst(0, 0, 0, 1);
      for (int k = 0; k < 20; k++) begin
         pin_in = NI'(k * 24593) ^ 18'h2C71D; tick();
      end
      setst(0, 0, 0, 0);
      snap = m_in;
      read_chain(rd);
      chk(rd[NC-1:NO] === snap, "R8", 36'(rd[NC-1:NO]), 36'(snap));

      // R9: zero seed escapes to 1, then shifts
      opcode = 8'h0A; load(18'h00000);
      rti(1);
      chk(pad_out === 18'h00001, "R9", 36'(pad_out), 36'h1);
      rti(1);
      chk(pad_out === 18'h00002, "R9", 36'(pad_out), 36'h2);
      load(18'h20000); rti(1);
      chk(pad_out === 18'h00001, "R9", 36'(pad_out), 36'h1);
      rti(40);

      // R10: count wraps
      opcode = 8'h0C; load(18'h3FFFE);
      rti(1);
      chk(pad_out === 18'h3FFFF, "R10", 36'(pad_out), 36'h3FFFF);
      rti(1);
      chk(pad_out === 18'h00000, "R10", 36'(pad_out), 36'h0);
      rti(1);
      chk(pad_out === 18'h00001, "R10", 36'(pad_out), 36'h1);

      // R11: signature and count together
      opcode = 8'h0F; load(18'h00010); capture();
      setst(0, 0, 0, 1);
      for (int k = 0; k < 5; k++) begin
         pin_in = NI'(k * 7919) ^ 18'h155AA; tick();
      end
      setst(0, 0, 0, 0);
      chk(pad_out === 18'h00015, "R11", 36'(pad_out), 36'h15);
      snap = m_in;
      read_chain(rd);
      chk(rd[NC-1:NO] === snap, "R11", 36'(rd[NC-1:NO]), 36'(snap));

      // R12: toggle inverts outputs and samples inputs
      opcode = 8'h00; load(18'h0F0F0);
      opcode = 8'h11; pin_in = 18'h2D2D2;
      rti(1);
      chk(pad_out === 18'h30F0F, "R12", 36'(pad_out), 36'h30F0F);
      rti(1);
      chk(pad_out === 18'h0F0F0, "R12", 36'(pad_out), 36'h0F0F0);
      read_chain(rd);
      chk(rd[NC-1:NO] === 18'h2D2D2, "R12", 36'(rd[NC-1:NO]), 36'h2D2D2);

      // R14: bypass instruction keeps core path during scan traffic
      opcode = 8'hFF;
      for (int k = 0; k < 6; k++) begin
         core_out = NO'(k * 4099); core_oe = k[0];
         tdi = k[1]; setst(k == 0, k != 0, 0, 0); tick();
      end
      setst(0, 0, 0, 0);
      chk(pad_out === core_out && pad_oe === core_oe, "R14", 36'(pad_out), 36'(core_out));

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule